// File: doc/BRIEF.md
# Capture-Compare Timer with Edge Demodulator

This block is an up-counting timer built around a single count register. Two compare channels watch the count, and one capture register records it. Mode bits set the job of the timer. It can run free as a timer or an event counter. It can generate a square wave on its output flip-flop. It can measure the spacing of input edges, restarting on an external edge or on an internal strobe. It can also recover data bits from a Manchester or biphase coded line. A separate clock module and a serial shift register are expected around it. Here the count source is picked by a select field, and recovered bits leave on a data/valid pair.

The external input passes through a synchronizer and a history flop. A programmable selector turns its transitions into edge events. Each compare channel has an enable and a one-shot option. Matches toggle the output flip-flop and raise one-cycle interrupt pulses. In the two demodulation modes, compare channel 1 holds the timing threshold. An edge that arrives once the count is beyond that value is taken as a bit decision point.

Top module: `etd_top`

## Requirements
- R1: The count is CNT_W bits wide (default 8) and resets to 0. It advances by one on each tick and wraps from all ones to 0 outside the demodulation modes. The tick comes from `clk_sel`: 0 means every cycle, 1 means `ext_tick`, 2 means each selected input edge, and 3 means no tick. After reset every output is 0.
- R2: `edge_sel` picks the input events. 0 means none, 1 means rising, 2 means falling, and 3 means both. A change on `pin_in` takes effect at the second rising clock edge after it is applied.
- R3: When `edge_irq_en` is 1, each selected edge event gives a one-cycle `edge_irq` pulse. When it is 0, no pulse appears.
- R4: In mode 2 (external restart), a selected edge copies the count into the capture register and sets the count to 0. This takes priority over the tick.
- R5: In mode 3 (internal restart), a high `trig_strobe` copies the count into the capture register and sets the count to 0.
- R6: A compare channel matches when it is armed, a tick occurs and the count equals its value. The match gives a one-cycle pulse on that channel's interrupt in the next cycle. In mode 1 a match from either channel sets the count to 0 in place of the increment.
- R7: With its one-shot bit set, a channel matches only once. It is armed again only after its enable has been taken low and then high.
- R8: `tmr_out` toggles once for each match. Two matches in the same cycle leave it unchanged. A high `preset_load` loads `preset_val` and overrides any toggle.
- R9: The capture register changes only on a restart or on an accepted demodulation edge. Otherwise it holds its value.
- R10: Mode 4 is Manchester. A selected edge with a count greater than `cmp1` is accepted. It gives a one-cycle `bit_valid` and sets `bit_data` to the new input level. It also captures the count and restarts it. An edge at or below the threshold is ignored.
- R11: Mode 5 is biphase. An edge at or below the threshold sets a mid-bit flag and does not restart the count. An accepted edge reports that flag on `bit_data`, with a mid-bit edge meaning 1. It then clears the flag and restarts the count.
- R12: In modes 4 and 5 the count stops at all ones instead of wrapping, and compare matches are blocked while it is there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 2 | Count source select |
| ext_tick | input | 1 | External count tick |
| pin_in | input | 1 | External input line |
| edge_sel | input | 2 | Edge event select |
| edge_irq_en | input | 1 | Edge interrupt enable |
| trig_strobe | input | 1 | Internal restart strobe |
| mode | input | 3 | Operating mode (6 and 7 behave as mode 0) |
| cmp1 | input | CNT_W | Compare value 1, also the demodulation threshold |
| cmp2 | input | CNT_W | Compare value 2 |
| cmp1_en | input | 1 | Compare 1 enable |
| cmp2_en | input | 1 | Compare 2 enable |
| cmp1_single | input | 1 | Compare 1 one-shot |
| cmp2_single | input | 1 | Compare 2 one-shot |
| preset_load | input | 1 | Load output flip-flop |
| preset_val | input | 1 | Level to load |
| tmr_out | output | 1 | Timer output flip-flop |
| cmp1_irq | output | 1 | Compare 1 match pulse |
| cmp2_irq | output | 1 | Compare 2 match pulse |
| edge_irq | output | 1 | Edge event pulse |
| cnt_val | output | CNT_W | Current count |
| cap_val | output | CNT_W | Captured count |
| bit_data | output | 1 | Recovered data bit |
| bit_valid | output | 1 | Recovered bit strobe |

## Verification
The count, the capture register, the compare interrupts and `tmr_out` react to their control inputs at the first rising edge after those inputs are applied. Anything that starts at `pin_in` (edge interrupts, restarts, recovered bits) lands one rising edge later, because of the synchronizer and history flops. The bench changes inputs only at falling edges and advances a reference model by one cycle per rising edge. It compares each output with the model at the next falling edge, so every comparison falls in the cycle where the result is due. Directed sequences then count pulses and collect recovered bits over known windows.

// File: rtl/etd_pkg.sv
package etd_pkg;

  localparam int unsigned N_CMP = 2;

  typedef enum logic [2:0] {
    MD_FREE     = 3'd0,
    MD_CLR_CMP  = 3'd1,
    MD_EXT_RST  = 3'd2,
    MD_INT_RST  = 3'd3,
    MD_MANCH    = 3'd4,
    MD_BIPH     = 3'd5,
    MD_SPARE6   = 3'd6,
    MD_SPARE7   = 3'd7
  } tmode_e;

  typedef enum logic [1:0] {
    ES_NONE = 2'd0,
    ES_RISE = 2'd1,
    ES_FALL = 2'd2,
    ES_BOTH = 2'd3
  } esel_e;

  typedef enum logic [1:0] {
    CS_SYS  = 2'd0,
    CS_EXT  = 2'd1,
    CS_EVT  = 2'd2,
    CS_HOLD = 2'd3
  } csel_e;

  function automatic logic is_demod(tmode_e m);
    return (m == MD_MANCH) || (m == MD_BIPH);
  endfunction

endpackage

// File: rtl/etd_edge_det.sv
module etd_edge_det #(
  parameter int unsigned SYNC_STAGES = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pin_i,
  input  etd_pkg::esel_e sel_i,
  input  logic           irq_en_i,
  output logic           ev_o,
  output logic           lvl_o,
  output logic           edge_irq_o
);
  import etd_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   hist_q, hist_d;
  logic                   irq_q, irq_d;
  logic                   rise, fall;

  assign sync_d[0] = pin_i;
  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_chain
    assign sync_d[i] = sync_q[i-1];
  end

  always_comb begin
    lvl_o  = sync_q[SYNC_STAGES-1];
    hist_d = lvl_o;
    rise   = lvl_o & ~hist_q;
    fall   = ~lvl_o & hist_q;
    unique case (sel_i)
      ES_NONE: ev_o = 1'b0;
      ES_RISE: ev_o = rise;
      ES_FALL: ev_o = fall;
      default: ev_o = rise | fall;
    endcase
    irq_d = ev_o & irq_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
      irq_q  <= irq_d;
    end
  end

  assign edge_irq_o = irq_q;

  // R3
  edge_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_irq_o |-> $past(irq_en_i));

endmodule

// File: rtl/etd_counter.sv
module etd_counter #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned N_CMP = etd_pkg::N_CMP
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  etd_pkg::tmode_e             mode_i,
  input  etd_pkg::csel_e              csel_i,
  input  logic                        ext_tick_i,
  input  logic                        ev_i,
  input  logic                        trig_i,
  input  logic [N_CMP-1:0][CNT_W-1:0] cmp_i,
  input  logic [N_CMP-1:0]            en_i,
  input  logic [N_CMP-1:0]            single_i,
  output logic [CNT_W-1:0]            cnt_o,
  output logic [CNT_W-1:0]            cap_o,
  output logic [N_CMP-1:0]            hit_o,
  output logic [N_CMP-1:0]            irq_o,
  output logic                        accept_o
);
  import etd_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cap_q;
  logic             cap_en;
  logic [N_CMP-1:0] done_q, done_d;
  logic [N_CMP-1:0] irq_q;
  logic [N_CMP-1:0] armed, hit;
  logic             tick, tick_eff, sat;
  logic             rst_ext, rst_int, restart;

  always_comb begin
    unique case (csel_i)
      CS_SYS:  tick = 1'b1;
      CS_EXT:  tick = ext_tick_i;
      CS_EVT:  tick = ev_i;
      default: tick = 1'b0;
    endcase
    sat      = is_demod(mode_i) && (cnt_q == CNT_MAX);
    tick_eff = tick & ~sat;
  end

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    assign armed[g]  = en_i[g] & ~(single_i[g] & done_q[g]);
    assign hit[g]    = armed[g] & tick_eff & (cnt_q == cmp_i[g]);
    assign done_d[g] = en_i[g] ? (done_q[g] | hit[g]) : 1'b0;
  end

  always_comb begin
    rst_ext  = (mode_i == MD_EXT_RST) & ev_i;
    rst_int  = (mode_i == MD_INT_RST) & trig_i;
    accept_o = is_demod(mode_i) & ev_i & (cnt_q > cmp_i[0]);
    restart  = rst_ext | rst_int | accept_o;
    cap_en   = restart;
    if (restart)
      cnt_d = '0;
    else if ((mode_i == MD_CLR_CMP) && (|hit))
      cnt_d = '0;
    else if (tick_eff)
      cnt_d = cnt_q + 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= '0;
      irq_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
      irq_q  <= hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cap_q <= '0;
    else if (cap_en)
      cap_q <= cnt_q;
  end

  assign cnt_o = cnt_q;
  assign cap_o = cap_q;
  assign hit_o = hit;
  assign irq_o = irq_q;

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0)));

  // R6
  cmp0_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q[0] |-> ($past(cnt_q) == $past(cmp_i[0])));

  // R6
  cmp1_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q[1] |-> ($past(cnt_q) == $past(cmp_i[1])));

  // R9
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_i || trig_i) |=> $stable(cap_q));

  // R12
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_demod(mode_i) && (cnt_q == CNT_MAX) && !ev_i) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/etd_demod.sv
module etd_demod (
  input  logic            clk,
  input  logic            rst_n,
  input  etd_pkg::tmode_e mode_i,
  input  logic            ev_i,
  input  logic            accept_i,
  input  logic            lvl_i,
  output logic            bit_data_o,
  output logic            bit_valid_o
);
  import etd_pkg::*;

  logic mid_q, mid_d;
  logic bd_q, bd_d;
  logic bv_q, bv_d;

  always_comb begin
    if (mode_i != MD_BIPH)
      mid_d = 1'b0;
    else if (accept_i)
      mid_d = 1'b0;
    else if (ev_i)
      mid_d = 1'b1;
    else
      mid_d = mid_q;
    bv_d = accept_i;
    if (accept_i)
      bd_d = (mode_i == MD_MANCH) ? lvl_i : mid_q;
    else
      bd_d = bd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q <= 1'b0;
      bd_q  <= 1'b0;
      bv_q  <= 1'b0;
    end else begin
      mid_q <= mid_d;
      bd_q  <= bd_d;
      bv_q  <= bv_d;
    end
  end

  assign bit_data_o  = bd_q;
  assign bit_valid_o = bv_q;

  // R10
  bit_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid_o |-> $past(ev_i));

  // R11
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid_o |-> $stable(bit_data_o));

endmodule

// File: rtl/etd_outff.sv
module etd_outff #(
  parameter int unsigned N_CMP = etd_pkg::N_CMP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CMP-1:0] hit_i,
  input  logic             load_i,
  input  logic             val_i,
  output logic             out_o
);
  logic out_q, out_d;

  always_comb begin
    if (load_i)
      out_d = val_i;
    else
      out_d = out_q ^ (^hit_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      out_q <= 1'b0;
    else
      out_q <= out_d;
  end

  assign out_o = out_q;

  // R8
  out_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q != $past(out_q)) |-> $past(load_i || (|hit_i)));

endmodule

// File: rtl/etd_top.sv
module etd_top #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       clk_sel,
  input  logic             ext_tick,
  input  logic             pin_in,
  input  logic [1:0]       edge_sel,
  input  logic             edge_irq_en,
  input  logic             trig_strobe,
  input  logic [2:0]       mode,
  input  logic [CNT_W-1:0] cmp1,
  input  logic [CNT_W-1:0] cmp2,
  input  logic             cmp1_en,
  input  logic             cmp2_en,
  input  logic             cmp1_single,
  input  logic             cmp2_single,
  input  logic             preset_load,
  input  logic             preset_val,
  output logic             tmr_out,
  output logic             cmp1_irq,
  output logic             cmp2_irq,
  output logic             edge_irq,
  output logic [CNT_W-1:0] cnt_val,
  output logic [CNT_W-1:0] cap_val,
  output logic             bit_data,
  output logic             bit_valid
);
  import etd_pkg::*;

  localparam int unsigned NC = N_CMP;

  logic [1:0]                rs_q;
  logic                      rst_ns;
  tmode_e                    mode_e;
  logic                      ev, lvl, accept;
  logic [NC-1:0][CNT_W-1:0]  cmp_vec;
  logic [NC-1:0]             en_vec, single_vec, hit_vec, irq_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rs_q <= 2'b00;
    else
      rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  assign mode_e     = tmode_e'(mode);
  assign cmp_vec    = {cmp2, cmp1};
  assign en_vec     = {cmp2_en, cmp1_en};
  assign single_vec = {cmp2_single, cmp1_single};

  etd_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_ns),
    .pin_i      (pin_in),
    .sel_i      (esel_e'(edge_sel)),
    .irq_en_i   (edge_irq_en),
    .ev_o       (ev),
    .lvl_o      (lvl),
    .edge_irq_o (edge_irq)
  );

  etd_counter #(.CNT_W(CNT_W), .N_CMP(NC)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_ns),
    .mode_i     (mode_e),
    .csel_i     (csel_e'(clk_sel)),
    .ext_tick_i (ext_tick),
    .ev_i       (ev),
    .trig_i     (trig_strobe),
    .cmp_i      (cmp_vec),
    .en_i       (en_vec),
    .single_i   (single_vec),
    .cnt_o      (cnt_val),
    .cap_o      (cap_val),
    .hit_o      (hit_vec),
    .irq_o      (irq_vec),
    .accept_o   (accept)
  );

  etd_demod u_dem (
    .clk         (clk),
    .rst_n       (rst_ns),
    .mode_i      (mode_e),
    .ev_i        (ev),
    .accept_i    (accept),
    .lvl_i       (lvl),
    .bit_data_o  (bit_data),
    .bit_valid_o (bit_valid)
  );

  etd_outff #(.N_CMP(NC)) u_out (
    .clk    (clk),
    .rst_n  (rst_ns),
    .hit_i  (hit_vec),
    .load_i (preset_load),
    .val_i  (preset_val),
    .out_o  (tmr_out)
  );

  assign cmp1_irq = irq_vec[0];
  assign cmp2_irq = irq_vec[1];

  // R7
  single_once_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (cmp1_irq && cmp1_single && $past(cmp1_en && cmp1_single)) |=> !cmp1_irq);

endmodule

// File: tb/tb_etd_top.sv
module tb_etd_top;

  localparam real HALF = 4.0;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] clk_sel;
  logic       ext_tick, pin_in, edge_irq_en, trig_strobe;
  logic [1:0] edge_sel;
  logic [2:0] mode;
  logic [7:0] cmp1, cmp2;
  logic       cmp1_en, cmp2_en, cmp1_single, cmp2_single;
  logic       preset_load, preset_val;
  logic       tmr_out, cmp1_irq, cmp2_irq, edge_irq, bit_data, bit_valid;
  logic [7:0] cnt_val, cap_val;

  always #(HALF) clk = ~clk;

  etd_top dut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_tick(ext_tick),
    .pin_in(pin_in), .edge_sel(edge_sel), .edge_irq_en(edge_irq_en),
    .trig_strobe(trig_strobe), .mode(mode), .cmp1(cmp1), .cmp2(cmp2),
    .cmp1_en(cmp1_en), .cmp2_en(cmp2_en), .cmp1_single(cmp1_single),
    .cmp2_single(cmp2_single), .preset_load(preset_load),
    .preset_val(preset_val), .tmr_out(tmr_out), .cmp1_irq(cmp1_irq),
    .cmp2_irq(cmp2_irq), .edge_irq(edge_irq), .cnt_val(cnt_val),
    .cap_val(cap_val), .bit_data(bit_data), .bit_valid(bit_valid)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  // reference model state
  logic       m_p1, m_p2, m_out, m_irq1, m_irq2, m_eirq, m_bv, m_bd, m_mid;
  logic [7:0] m_cnt, m_cap;
  logic [1:0] m_done;

  int   n_irq1;
  int   max_cnt;
  int   rx_n;
  logic rx_bits [0:31];

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (ok !== 1'b1) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_p1 = 0; m_p2 = 0; m_out = 0; m_irq1 = 0; m_irq2 = 0; m_eirq = 0;
    m_bv = 0; m_bd = 0; m_mid = 0; m_cnt = 0; m_cap = 0; m_done = 0;
  endtask

  // One clock: predict from present inputs, let the DUT clock, compare at the falling edge.
  task automatic step();
    logic ev, tk, te, dm, acc, take;
    logic [1:0] h;
    logic [7:0] ncnt, ncap;
    logic nout, nmid, nbd;
    case (edge_sel)
      2'd0: ev = 1'b0;
      2'd1: ev = m_p1 & ~m_p2;
      2'd2: ev = ~m_p1 & m_p2;
      default: ev = m_p1 ^ m_p2;
    endcase
    case (clk_sel)
      2'd0: tk = 1'b1;
      2'd1: tk = ext_tick;
      2'd2: tk = ev;
      default: tk = 1'b0;
    endcase
    dm = (mode == 3'd4) || (mode == 3'd5);
    te = tk & ~(dm && (m_cnt == 8'hFF));
    h[0] = cmp1_en & ~(cmp1_single & m_done[0]) & te & (m_cnt == cmp1);
    h[1] = cmp2_en & ~(cmp2_single & m_done[1]) & te & (m_cnt == cmp2);
    acc  = dm & ev & (m_cnt > cmp1);
    take = ((mode == 3'd2) & ev) | ((mode == 3'd3) & trig_strobe) | acc;
    if (take) ncnt = 8'd0;
    else if ((mode == 3'd1) && (|h)) ncnt = 8'd0;
    else if (te) ncnt = m_cnt + 8'd1;
    else ncnt = m_cnt;
    ncap = take ? m_cnt : m_cap;
    if (mode != 3'd5) nmid = 1'b0;
    else if (acc) nmid = 1'b0;
    else if (ev) nmid = 1'b1;
    else nmid = m_mid;
    nbd  = acc ? ((mode == 3'd4) ? m_p1 : m_mid) : m_bd;
    nout = preset_load ? preset_val : (m_out ^ h[0] ^ h[1]);
    @(posedge clk);
    @(negedge clk);
    m_p2 = m_p1; m_p1 = pin_in;
    m_cnt = ncnt; m_cap = ncap; m_mid = nmid; m_bd = nbd; m_bv = acc;
    m_out = nout; m_irq1 = h[0]; m_irq2 = h[1]; m_eirq = ev & edge_irq_en;
    m_done[0] = cmp1_en ? (m_done[0] | h[0]) : 1'b0;
    m_done[1] = cmp2_en ? (m_done[1] | h[1]) : 1'b0;
    chk(cnt_val === m_cnt, "R1/R4/R5/R6/R12 count", int'(cnt_val), int'(m_cnt));
    chk(cap_val === m_cap, "R9 capture", int'(cap_val), int'(m_cap));
    chk(cmp1_irq === m_irq1, "R6/R7 cmp1_irq", int'(cmp1_irq), int'(m_irq1));
    chk(cmp2_irq === m_irq2, "R6/R7 cmp2_irq", int'(cmp2_irq), int'(m_irq2));
    chk(edge_irq === m_eirq, "R2/R3 edge_irq", int'(edge_irq), int'(m_eirq));
    chk(tmr_out === m_out, "R8 tmr_out", int'(tmr_out), int'(m_out));
    chk(bit_valid === m_bv, "R10/R11 bit_valid", int'(bit_valid), int'(m_bv));
    chk(bit_data === m_bd, "R10/R11 bit_data", int'(bit_data), int'(m_bd));
    if (cmp1_irq) n_irq1++;
    if (int'(cnt_val) > max_cnt) max_cnt = int'(cnt_val);
    if (bit_valid && rx_n < 32) begin
      rx_bits[rx_n] = bit_data;
      rx_n++;
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(HALF * 2.0 * 150000.0);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [15:0] pat;
    int c;
    void'($urandom(32'h5EED_1234));
    rst_n = 0; clk_sel = 2'd3; ext_tick = 0; pin_in = 0; edge_sel = 0;
    edge_irq_en = 0; trig_strobe = 0; mode = 0; cmp1 = 0; cmp2 = 0;
    cmp1_en = 0; cmp2_en = 0; cmp1_single = 0; cmp2_single = 0;
    preset_load = 0; preset_val = 0;
    model_reset();
    n_irq1 = 0; max_cnt = 0; rx_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(cnt_val === 8'd0 && cap_val === 8'd0, "R1 reset count/capture", int'(cnt_val), 0);
    chk({tmr_out, cmp1_irq, cmp2_irq, edge_irq, bit_data, bit_valid} === 6'd0,
        "R1 reset outputs", int'({tmr_out, cmp1_irq, cmp2_irq, edge_irq, bit_data, bit_valid}), 0);

    // R8 preset load, then hold
    preset_val = 1; preset_load = 1; step(); preset_load = 0;
    chk(tmr_out === 1'b1, "R8 preset", int'(tmr_out), 1);
    repeat (5) step();
    chk(tmr_out === 1'b1, "R8 output holds", int'(tmr_out), 1);

    // R4 and R2: external restart on rising edges only
    mode = 3'd2; clk_sel = 2'd0; edge_sel = 2'd1; edge_irq_en = 1;
    pin_in = 1; repeat (2) step();
    chk(cnt_val === 8'd0, "R4 restart clears count", int'(cnt_val), 0);
    pin_in = 0; repeat (10) step();
    pin_in = 1; step();
    chk(edge_irq === 1'b0, "R2 not yet due", int'(edge_irq), 0);
    step();
    chk(edge_irq === 1'b1, "R2 edge due second clock", int'(edge_irq), 1);
    chk(cap_val === 8'd11, "R4 captured spacing", int'(cap_val), 11);
    chk(cnt_val === 8'd0, "R4 count restarted", int'(cnt_val), 0);
    edge_irq_en = 0; pin_in = 0; repeat (2) step();
    chk(edge_irq === 1'b0, "R3 falling edge not selected", int'(edge_irq), 0);

    // R5 internal strobe restart
    mode = 3'd3; repeat (7) step();
    c = int'(cnt_val);
    trig_strobe = 1; step(); trig_strobe = 0;
    chk(int'(cap_val) == c, "R5 strobe capture", int'(cap_val), c);
    chk(cnt_val === 8'd0, "R5 strobe restart", int'(cnt_val), 0);

    // R7 one-shot compare
    mode = 3'd0; cmp1 = 8'd20; cmp1_en = 1; cmp1_single = 1; n_irq1 = 0;
    repeat (600) step();
    chk(n_irq1 == 1, "R7 single match", n_irq1, 1);
    cmp1_en = 0; step(); cmp1_en = 1; n_irq1 = 0;
    repeat (300) step();
    chk(n_irq1 == 1, "R7 rearm after enable", n_irq1, 1);

    // R6 clear on compare
    mode = 3'd1; cmp1 = 8'd9; cmp1_single = 0;
    repeat (300) step();
    n_irq1 = 0; max_cnt = 0;
    repeat (100) step();
    chk(n_irq1 == 10, "R6 period of ten", n_irq1, 10);
    chk(max_cnt <= 9, "R6 count bounded", max_cnt, 9);
    cmp1_en = 0;

    // R10 Manchester, R12 saturation
    mode = 3'd4; edge_sel = 2'd3; cmp1 = 8'd11; pin_in = 0;
    repeat (300) step();
    chk(cnt_val === 8'hFF, "R12 saturates", int'(cnt_val), 255);
    pat = 16'hA6C3; rx_n = 0;
    for (int i = 15; i >= 0; i--) begin
      pin_in = ~pat[i]; repeat (8) step();
      pin_in = pat[i];  repeat (8) step();
    end
    repeat (20) step();
    chk(rx_n == 16, "R10 manchester bit count", rx_n, 16);
    for (int i = 0; i < 16; i++)
      chk(rx_bits[i] === pat[15-i], "R10 manchester bit", int'(rx_bits[i]), int'(pat[15-i]));

    // R11 biphase: first boundary reports a cleared flag
    mode = 3'd5; repeat (300) step();
    pat = 16'h5C29; rx_n = 0;
    for (int i = 15; i >= 0; i--) begin
      pin_in = ~pin_in; repeat (8) step();
      if (pat[i]) pin_in = ~pin_in;
      repeat (8) step();
    end
    pin_in = ~pin_in; repeat (20) step();
    chk(rx_n == 17, "R11 biphase bit count", rx_n, 17);
    chk(rx_bits[0] === 1'b0, "R11 leading boundary", int'(rx_bits[0]), 0);
    for (int i = 0; i < 16; i++)
      chk(rx_bits[i+1] === pat[15-i], "R11 biphase bit", int'(rx_bits[i+1]), int'(pat[15-i]));

    // random segments against the model
    for (int seg = 0; seg < 40; seg++) begin
      mode        = 3'($urandom % 8);
      clk_sel     = 2'($urandom % 4);
      edge_sel    = 2'($urandom % 4);
      cmp1        = ($urandom % 4 == 0) ? 8'($urandom % 256) : 8'($urandom % 40);
      cmp2        = ($urandom % 4 == 0) ? 8'($urandom % 256) : 8'($urandom % 40);
      cmp1_en     = 1'($urandom % 2);
      cmp2_en     = 1'($urandom % 2);
      cmp1_single = 1'($urandom % 2);
      cmp2_single = 1'($urandom % 2);
      edge_irq_en = 1'($urandom % 2);
      for (int k = 0; k < 400; k++) begin
        if ($urandom % 8 == 0) pin_in = ~pin_in;
        ext_tick    = 1'($urandom % 2);
        trig_strobe = ($urandom % 32 == 0);
        preset_load = ($urandom % 64 == 0);
        preset_val  = 1'($urandom % 2);
        step();
      end
    end

    finished = 1'b1;
    summary();
  end

endmodule